// File: doc/BRIEF.md
# PSE Detection and Classification Sequencer

This block sequences one power-sourcing port from an unpowered start to power grant. While it searches for a device it repeats a three-level resistance probe. When it sees a valid signature it either grants power at once or first runs a one-event or two-event classification. Classification may end in a power grant or in a class-based denial. The block drives a voltage-setpoint code and a current-limit code into an abstracted output stage. It reads a signature-resistance value and a class-current code from an abstracted measurement front end, and it drives a status LED.

All durations are counted in ticks of a 1 ms `tick` strobe. The operating mode is captured only while reset is asserted. The modes are 0 (15.4 W, no classification), 1 (30 W, no classification), 2 (one-event classification, classes 0..3 accepted, 15.4 W grant) and 3 (two-event classification, classes 0..4 accepted, 30 W grant).

States and transitions:
- ST_REST (0 V) goes to ST_PROBE_A after 270 ticks.
- ST_PROBE_A (4 V) goes to ST_PROBE_B after 20 ticks.
- ST_PROBE_B (8 V) goes to ST_PROBE_C after 20 ticks.
- ST_PROBE_C (4 V) ends after 50 ticks. With a bad signature it returns to ST_REST. With a good one it goes to ST_POWER in modes 0/1, to ST_CLASS_B in mode 2, and to ST_CLASS_A in mode 3.
- ST_CLASS_A goes to ST_MARK after 30 ticks.
- ST_MARK goes to ST_CLASS_B after 10 ticks.
- ST_CLASS_B ends after 30 ticks. It goes to ST_POWER if the class is accepted and to ST_DENY if not.
- ST_DENY goes to ST_REST after 2000 ticks.
- ST_POWER goes to ST_REST when `drop_pwr_i` is seen.

Top module: `pse_seq`

## Requirements
- R1: `mode_i` is captured only while `rst_n` is low; changing it after reset has no effect on the sequence.
- R2: While reset is held, and directly after it, `vset_o`=0 (0 V), `ilim_o`=0 (detect limit) and `led_o`=0.
- R3: A search cycle outputs `vset_o` codes 0, 1 (4 V), 2 (8 V) and 1 for 270, 20, 20 and 50 ticks, which gives a 360-tick period. `ilim_o` stays 0 (5 mA) throughout.
- R4: `sig_i` (units of 100 Ω) is sampled on the last tick of the final 4 V step. A value from 170 to 290 inclusive is valid. Any other value restarts the cycle at 0 V.
- R5: In modes 0 and 1 a valid signature leads directly to power: `vset_o`=5, with `ilim_o`=2 in mode 0 and `ilim_o`=3 in mode 1. No class or mark code is ever output in these modes.
- R6: In mode 2 a valid signature is followed by one pulse of `vset_o`=4 (18 V) with `ilim_o`=1 (75 mA) for 30 ticks. Classes 0..3 lead to power with `ilim_o`=2.
- R7: In mode 3 the sequence is 18 V for 30 ticks, then `vset_o`=3 (8.5 V mark) for 10 ticks, then 18 V for 30 ticks. Classes 0..4 lead to power with `ilim_o`=3.
- R8: `class_i` is sampled on the last tick of the final class pulse. A class outside the accepted range causes a denial: 0 V and `ilim_o`=0 for 2000 ticks, then a fresh cycle at 0 V.
- R9: During a denial the LED starts on and toggles every 50 ticks (10 Hz).
- R10: While searching or classifying, the LED starts off and toggles every 333 ticks (about 1.5 Hz).
- R11: While powered the LED is steadily on. `drop_pwr_i` returns the port to 0 V on the next clock edge, starting a full new search period.
- R12: Durations advance only on clocks where `tick` is high. Without ticks every output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; mode is captured while low |
| tick | input | 1 | 1 ms time-base strobe |
| mode_i | input | 2 | Operating mode code |
| sig_i | input | SIG_W | Measured signature resistance, 100 Ω units |
| class_i | input | CLASS_W | Measured class code |
| drop_pwr_i | input | 1 | Remove power and restart detection |
| vset_o | output | 3 | Voltage-setpoint code |
| ilim_o | output | 2 | Current-limit code |
| led_o | output | 1 | Status LED |

## Verification
`vset_o` and `ilim_o` decode the state register, so they change on the same clock edge as the tick that ends a dwell. A step of N ticks therefore shows up exactly N ticked edges after its entry edge. The LED register reloads on the edge where the pattern changes and toggles on the tick that completes each half period. The bench counts ticked edges from the release of reset and samples 1 ns after the edge of interest, never on the edge itself. Each boundary is probed one tick before and on the switching tick. Table vectors are read 50 ticks after the sequence outcome, which separates a denial (LED already toggled off) from a repeated search (LED still on).

// File: rtl/pse_seq_pkg.sv
package pse_seq_pkg;

    typedef enum logic [3:0] {
        ST_REST,
        ST_PROBE_A,
        ST_PROBE_B,
        ST_PROBE_C,
        ST_CLASS_A,
        ST_MARK,
        ST_CLASS_B,
        ST_DENY,
        ST_POWER
    } seq_state_t;

    typedef enum logic [1:0] {
        MODE_P15_NOCLS = 2'd0,
        MODE_P30_NOCLS = 2'd1,
        MODE_ONE_EVT   = 2'd2,
        MODE_TWO_EVT   = 2'd3
    } port_mode_t;

    typedef enum logic [1:0] {
        LED_SLOW = 2'd0,
        LED_FAST = 2'd1,
        LED_ON   = 2'd2
    } led_pat_t;

    localparam logic [2:0] VSET_ZERO     = 3'd0;
    localparam logic [2:0] VSET_PROBE_LO = 3'd1;
    localparam logic [2:0] VSET_PROBE_HI = 3'd2;
    localparam logic [2:0] VSET_MARK     = 3'd3;
    localparam logic [2:0] VSET_CLASS    = 3'd4;
    localparam logic [2:0] VSET_FULL     = 3'd5;

    localparam logic [1:0] ILIM_DETECT = 2'd0;
    localparam logic [1:0] ILIM_CLASS  = 2'd1;
    localparam logic [1:0] ILIM_PWR_LO = 2'd2;
    localparam logic [1:0] ILIM_PWR_HI = 2'd3;

endpackage

// File: rtl/pse_dwell_timer.sv
module pse_dwell_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    output logic [CNT_W-1:0] dwell
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dwell <= '0;
        end else if (restart) begin
            dwell <= '0;
        end else if (tick && dwell != CNT_TOP) begin
            dwell <= dwell + 1'b1;
        end
    end

    // R12: the dwell count only moves on a tick or a restart
    AST_DWELL_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(dwell)) else $error("dwell moved without tick"); // R12

endmodule

// File: rtl/pse_led_blinker.sv
module pse_led_blinker
    import pse_seq_pkg::*;
#(
    parameter int SLOW_HALF = 333,
    parameter int FAST_HALF = 50
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     restart,
    input  led_pat_t pat_next,
    output logic     led
);

    localparam int HALF_MAX = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int CNT_W    = $clog2(HALF_MAX + 1);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_HALF - 1);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_HALF - 1);

    led_pat_t         pat_q;
    logic [CNT_W-1:0] half_cnt;
    logic [CNT_W-1:0] half_last;

    always_comb begin
        half_last = (pat_q == LED_FAST) ? FAST_LAST : SLOW_LAST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q    <= LED_SLOW;
            half_cnt <= '0;
            led      <= 1'b0;
        end else if (restart) begin
            pat_q    <= pat_next;
            half_cnt <= '0;
            led      <= (pat_next != LED_SLOW);   // R9 fast starts on, R10 slow starts off
        end else if (tick && pat_q != LED_ON) begin
            if (half_cnt == half_last) begin
                half_cnt <= '0;
                led      <= ~led;
            end else begin
                half_cnt <= half_cnt + 1'b1;
            end
        end
    end

    AST_BLINK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        half_cnt <= SLOW_LAST || half_cnt <= FAST_LAST) else $error("blink count out of range"); // R10
    AST_STEADY_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_q == LED_ON && !restart) |=> led) else $error("steady LED dropped"); // R11

endmodule

// File: rtl/pse_seq.sv
module pse_seq
    import pse_seq_pkg::*;
#(
    parameter int SIG_W             = 10,
    parameter int CLASS_W           = 3,
    parameter int SIG_MIN           = 170,
    parameter int SIG_MAX           = 290,
    parameter int PERIOD_TICKS      = 360,
    parameter int PROBE_A_TICKS     = 20,
    parameter int PROBE_B_TICKS     = 20,
    parameter int PROBE_C_TICKS     = 50,
    parameter int CLASS_TICKS       = 30,
    parameter int MARK_TICKS        = 10,
    parameter int DENY_TICKS        = 2000,
    parameter int SEARCH_HALF_TICKS = 333,
    parameter int DENY_HALF_TICKS   = 50,
    parameter int ONE_EVT_MAX_CLASS = 3,
    parameter int TWO_EVT_MAX_CLASS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [1:0]         mode_i,
    input  logic [SIG_W-1:0]   sig_i,
    input  logic [CLASS_W-1:0] class_i,
    input  logic               drop_pwr_i,
    output logic [2:0]         vset_o,
    output logic [1:0]         ilim_o,
    output logic               led_o
);

    localparam int REST_TICKS = PERIOD_TICKS - PROBE_A_TICKS - PROBE_B_TICKS - PROBE_C_TICKS;
    localparam int MAX_AB     = (PROBE_A_TICKS > PROBE_B_TICKS) ? PROBE_A_TICKS : PROBE_B_TICKS;
    localparam int MAX_CM     = (CLASS_TICKS > MARK_TICKS) ? CLASS_TICKS : MARK_TICKS;
    localparam int MAX_RC     = (REST_TICKS > PROBE_C_TICKS) ? REST_TICKS : PROBE_C_TICKS;
    localparam int MAX_1      = (MAX_AB > MAX_CM) ? MAX_AB : MAX_CM;
    localparam int MAX_2      = (MAX_RC > DENY_TICKS) ? MAX_RC : DENY_TICKS;
    localparam int DUR_MAX    = (MAX_1 > MAX_2) ? MAX_1 : MAX_2;
    localparam int DUR_W      = $clog2(DUR_MAX + 1);

    localparam logic [SIG_W-1:0]   SIG_LO  = SIG_W'(SIG_MIN);
    localparam logic [SIG_W-1:0]   SIG_HI  = SIG_W'(SIG_MAX);
    localparam logic [CLASS_W-1:0] CLS_ONE = CLASS_W'(ONE_EVT_MAX_CLASS);
    localparam logic [CLASS_W-1:0] CLS_TWO = CLASS_W'(TWO_EVT_MAX_CLASS);

    seq_state_t       state_q;
    seq_state_t       state_d;
    port_mode_t       mode_q;
    logic [DUR_W-1:0] dwell;
    logic [DUR_W-1:0] dur_last;
    logic             at_end;
    logic             sig_ok;
    logic             class_ok;
    logic             restart;
    led_pat_t         pat_cur;
    led_pat_t         pat_nxt;
    logic             pat_restart;

    // R1: operating mode captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= port_mode_t'(mode_i);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_REST;
        end else begin
            state_q <= state_d;
        end
    end

    // dwell length of each timed state (last tick index)
    always_comb begin
        unique case (state_q)
            ST_REST:    dur_last = DUR_W'(REST_TICKS - 1);
            ST_PROBE_A: dur_last = DUR_W'(PROBE_A_TICKS - 1);
            ST_PROBE_B: dur_last = DUR_W'(PROBE_B_TICKS - 1);
            ST_PROBE_C: dur_last = DUR_W'(PROBE_C_TICKS - 1);
            ST_CLASS_A: dur_last = DUR_W'(CLASS_TICKS - 1);
            ST_MARK:    dur_last = DUR_W'(MARK_TICKS - 1);
            ST_CLASS_B: dur_last = DUR_W'(CLASS_TICKS - 1);
            ST_DENY:    dur_last = DUR_W'(DENY_TICKS - 1);
            default:    dur_last = DUR_W'(DUR_MAX);
        endcase
    end

    always_comb begin
        at_end   = tick && (dwell == dur_last);                       // R12
        sig_ok   = (sig_i >= SIG_LO) && (sig_i <= SIG_HI);            // R4
        class_ok = (mode_q == MODE_TWO_EVT) ? (class_i <= CLS_TWO)
                                            : (class_i <= CLS_ONE);   // R6 R7
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_REST:    if (at_end) state_d = ST_PROBE_A;
            ST_PROBE_A: if (at_end) state_d = ST_PROBE_B;
            ST_PROBE_B: if (at_end) state_d = ST_PROBE_C;
            ST_PROBE_C: begin
                if (at_end) begin
                    if (!sig_ok) begin
                        state_d = ST_REST;
                    end else begin
                        unique case (mode_q)
                            MODE_P15_NOCLS,
                            MODE_P30_NOCLS: state_d = ST_POWER;
                            MODE_ONE_EVT:   state_d = ST_CLASS_B;
                            MODE_TWO_EVT:   state_d = ST_CLASS_A;
                            default:        state_d = ST_REST;
                        endcase
                    end
                end
            end
            ST_CLASS_A: if (at_end) state_d = ST_MARK;
            ST_MARK:    if (at_end) state_d = ST_CLASS_B;
            ST_CLASS_B: if (at_end) state_d = class_ok ? ST_POWER : ST_DENY;
            ST_DENY:    if (at_end) state_d = ST_REST;
            ST_POWER:   if (drop_pwr_i) state_d = ST_REST;
            default:    state_d = ST_REST;
        endcase
    end

    function automatic led_pat_t pat_of(input seq_state_t s);
        unique case (s)
            ST_DENY:  return LED_FAST;
            ST_POWER: return LED_ON;
            default:  return LED_SLOW;
        endcase
    endfunction

    // outputs decoded from the state register
    always_comb begin
        vset_o = VSET_ZERO;
        ilim_o = ILIM_DETECT;
        unique case (state_q)
            ST_REST, ST_DENY: begin
                vset_o = VSET_ZERO;
                ilim_o = ILIM_DETECT;
            end
            ST_PROBE_A, ST_PROBE_C: begin
                vset_o = VSET_PROBE_LO;
                ilim_o = ILIM_DETECT;
            end
            ST_PROBE_B: begin
                vset_o = VSET_PROBE_HI;
                ilim_o = ILIM_DETECT;
            end
            ST_CLASS_A, ST_CLASS_B: begin
                vset_o = VSET_CLASS;
                ilim_o = ILIM_CLASS;
            end
            ST_MARK: begin
                vset_o = VSET_MARK;
                ilim_o = ILIM_CLASS;
            end
            ST_POWER: begin
                vset_o = VSET_FULL;
                ilim_o = (mode_q == MODE_P30_NOCLS || mode_q == MODE_TWO_EVT)
                         ? ILIM_PWR_HI : ILIM_PWR_LO;
            end
            default: begin
                vset_o = VSET_ZERO;
                ilim_o = ILIM_DETECT;
            end
        endcase
        restart     = (state_d != state_q);
        pat_cur     = pat_of(state_q);
        pat_nxt     = pat_of(state_d);
        pat_restart = (pat_nxt != pat_cur);
    end

    pse_dwell_timer #(
        .CNT_W (DUR_W)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (restart),
        .dwell   (dwell)
    );

    pse_led_blinker #(
        .SLOW_HALF (SEARCH_HALF_TICKS),
        .FAST_HALF (DENY_HALF_TICKS)
    ) blink_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .restart  (pat_restart),
        .pat_next (pat_nxt),
        .led      (led_o)
    );

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q)) else $error("mode changed after reset"); // R1
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !drop_pwr_i) |=> $stable(vset_o)) else $error("setpoint moved without tick"); // R12
    AST_NO_CLASS_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_P15_NOCLS || mode_q == MODE_P30_NOCLS)
        |-> (vset_o != VSET_CLASS && vset_o != VSET_MARK)) else $error("class pulse in skip mode"); // R5
    AST_MARK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (vset_o == VSET_MARK) |=> (vset_o == VSET_MARK || vset_o == VSET_CLASS)) else $error("mark not followed by class pulse"); // R7
    AST_POWER_LED: assert property (@(posedge clk) disable iff (!rst_n)
        (vset_o == VSET_FULL) |-> led_o) else $error("LED off while powered"); // R11
    AST_DENY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DENY && $past(state_q) != ST_DENY) |-> ($past(state_q) == ST_CLASS_B)) else $error("denial not from class pulse"); // R8

endmodule

// File: tb/pse_seq_tb_top.sv
`timescale 1ns/1ps
module pse_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic [1:0] mode = 2'd0;
    logic [9:0] sig = 10'd0;
    logic [2:0] cls = 3'd0;
    logic       drop = 1'b0;
    logic [2:0] vset;
    logic [1:0] ilim;
    logic       led;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pse_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .mode_i     (mode),
        .sig_i      (sig),
        .class_i    (cls),
        .drop_pwr_i (drop),
        .vset_o     (vset),
        .ilim_o     (ilim),
        .led_o      (led)
    );

    // vectors: mode, signature, class -> setpoint, limit, LED 50 ticks after outcome
    localparam int NV = 10;
    localparam int V_MODE [NV] = '{0,   1,   0,   1,   2,   2,   3,   3,   2,   3};
    localparam int V_SIG  [NV] = '{250, 170, 169, 291, 290, 200, 250, 250, 100, 290};
    localparam int V_CLS  [NV] = '{7,   0,   0,   0,   3,   4,   4,   5,   0,   0};
    localparam int E_VSET [NV] = '{5,   5,   0,   0,   5,   0,   5,   0,   0,   5};
    localparam int E_ILIM [NV] = '{2,   3,   0,   0,   2,   0,   3,   0,   0,   3};
    localparam int E_LED  [NV] = '{1,   1,   1,   1,   1,   0,   1,   0,   1,   1};

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input int m);
        rst_n = 1'b0;
        mode  = 2'(m);
        drop  = 1'b0;
        tick  = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // table walk: outcome time = 360 + class time of the mode (R6 R7)
        for (int i = 0; i < NV; i++) begin
            int ct;
            do_reset(V_MODE[i]);
            sig = 10'(V_SIG[i]);
            cls = 3'(V_CLS[i]);
            ct = (V_MODE[i] == 2) ? 30 : (V_MODE[i] == 3) ? 70 : 0;
            step(360 + ct + 50);
            check($sformatf("R4/R5/R6/R7/R8 vec%0d vset", i), vset, E_VSET[i]);
            check($sformatf("R5/R6/R7 vec%0d ilim", i), ilim, E_ILIM[i]);
            check($sformatf("R9/R10/R11 vec%0d led", i), led, E_LED[i]);
        end

        // directed: reset state, waveform, two-event timing, mode freeze
        rst_n = 1'b0;
        mode = 2'd3;
        sig = 10'd250;
        cls = 3'd4;
        repeat (3) @(posedge clk);
        #1;
        check("R2 reset vset", vset, 0);
        check("R2 reset ilim", ilim, 0);
        check("R2 reset led", led, 0);
        rst_n = 1'b1;
        step(5);
        mode = 2'd0;                      // R1: ignored after reset
        step(264);
        check("R3 rest end vset", vset, 0);
        step(1);
        check("R3 probe 4V vset", vset, 1);
        check("R3 probe limit", ilim, 0);
        step(20);
        check("R3 probe 8V vset", vset, 2);
        check("R3 8V limit", ilim, 0);
        step(20);
        check("R3 probe final 4V", vset, 1);
        step(22);
        check("R10 led before toggle", led, 0);
        step(1);
        check("R10 led slow toggle", led, 1);
        step(27);
        check("R1 R7 first class pulse", vset, 4);
        check("R7 class limit", ilim, 1);
        step(30);
        check("R7 mark pulse", vset, 3);
        step(9);
        check("R7 mark last tick", vset, 3);
        step(1);
        check("R7 second class pulse", vset, 4);
        step(29);
        check("R8 class last tick", vset, 4);
        step(1);
        check("R7 powered", vset, 5);
        check("R7 power limit", ilim, 3);
        check("R11 led on", led, 1);
        step(200);
        check("R11 led steady", led, 1);

        // drop power and fresh period
        drop = 1'b1;
        step(1);
        drop = 1'b0;
        check("R11 drop vset", vset, 0);
        check("R11 drop led", led, 0);
        step(269);
        check("R11 fresh rest", vset, 0);
        step(1);
        check("R11 fresh probe", vset, 1);

        // tick gating
        tick = 1'b0;
        step(100);
        check("R12 hold without tick", vset, 1);
        tick = 1'b1;
        step(19);
        check("R12 probe 4V still", vset, 1);
        step(1);
        check("R12 resumes 8V", vset, 2);

        // denial timing and fast blink
        do_reset(2);
        sig = 10'd250;
        cls = 3'd4;
        step(390);
        check("R8 deny vset", vset, 0);
        check("R8 deny limit", ilim, 0);
        check("R9 deny led starts on", led, 1);
        step(49);
        check("R9 deny led held", led, 1);
        step(1);
        check("R9 deny led toggle", led, 0);
        step(50);
        check("R9 deny led toggle again", led, 1);
        step(2169);
        check("R8 after deny rest", vset, 0);
        step(1);
        check("R8 deny length probe", vset, 1);
        check("R10 led off after deny", led, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule